// File: doc/BRIEF.md
# Overflow Message Doorbell Writer

This block turns a counter group's overflow condition into a message-signalled interrupt. Software programs a doorbell address, a 32-bit data word, a memory-attribute code and an interrupt enable through a small register window. When the qualified overflow condition rises, the block issues one single-beat posted write to the memory fabric on a valid/ready request channel. The write carries the doorbell address, the data word and the attribute code.

The overflow condition counts as qualified only while the enable is set and the doorbell address is non-zero. Clearing the address to zero therefore turns messaging off. Only one request is outstanding at any time. A second rising edge that arrives while a request waits is merged into it. After the handshake, the block sends nothing more until the overflow condition has fallen and risen again.

Back-pressure rules for the request channel: once `msg_valid` is high, it stays high, and `msg_addr`, `msg_data` and `msg_attr` stay unchanged, until a cycle in which `msg_ready` is also high. The transfer completes on that clock edge. `msg_valid` never depends on `msg_ready`. The payload is captured when the request launches, so register writes made while a request waits do not change that request.

Top module: `msi_doorbell_writer`

## Requirements
- R1: After reset, every register reads zero and `msg_valid` is low.
- R2: The doorbell address keeps only bits 51:2. The low word at offset 0x08 reads bits 1:0 as zero. The high word at offset 0x0C reads bits 31:20 (address bits 63:52) as zero. `msg_addr` never has those bits set.
- R3: The control word at offset 0x00 keeps only bit 0, the enable. The data word at offset 0x04 keeps all 32 bits. The attribute at offset 0x10 keeps bits 3:0, where the value 1 denotes device memory. Any other offset reads zero.
- R4: If the overflow input is sampled high at a clock edge, was low at the edge before, the enable is set and the address is non-zero, then `msg_valid` is high after that edge. The request carries the programmed address, data and attribute.
- R5: While the enable is clear, an overflow rise produces no request.
- R6: While the doorbell address is zero, an overflow rise produces no request.
- R7: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and the payload stay unchanged.
- R8: At most one request is outstanding. An overflow rise during a pending request is merged, and exactly one transfer results.
- R9: After a transfer, no further request is made while overflow stays high. A new request follows only after overflow falls and rises again.
- R10: The payload is taken from the registers when the request launches. Writes to the data or attribute registers during a pending request affect only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ofs | input | 5 | Register byte offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_ofs` (combinational) |
| ovf_in | input | 1 | Overflow condition from the counter group (level) |
| msg_valid | output | 1 | Write request valid |
| msg_ready | input | 1 | Write request accepted by the fabric |
| msg_addr | output | 64 | Doorbell address of the write |
| msg_data | output | 32 | Data word of the write |
| msg_attr | output | 4 | Memory-attribute code of the write |

## Verification
A stuck pending flag shows at the ports within one cycle. It appears either as a second transfer after a handshake or as a request that never drops. A lost edge history shows as a repeated message while overflow stays high, or as a missing message after it toggles. Payload that is not latched shows up after a register write made during a stall: the data or attribute changes while `msg_ready` is low, or the delayed transfer carries the new values instead of the old ones.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int REG_W = 32;
  localparam int OFS_W = 5;

  typedef enum logic [OFS_W-1:0] {
    OFS_CTRL    = 5'h00,
    OFS_DATA    = 5'h04,
    OFS_ADDR_LO = 5'h08,
    OFS_ADDR_HI = 5'h0C,
    OFS_ATTR    = 5'h10
  } cfg_ofs_e;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter int ADDR_BITS = 52,
  parameter int ATTR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [OFS_W-1:0]     ofs,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  output logic                 irq_en,
  output logic [63:0]          door_addr,
  output logic [REG_W-1:0]     msg_word,
  output logic [ATTR_W-1:0]    mem_attr
);
  localparam int HI_W = ADDR_BITS - 32;

  logic               en_q;
  logic [REG_W-1:0]   data_q;
  logic [ATTR_W-1:0]  attr_q;
  logic [31:2]        addr_lo_q;
  logic [63:0]        addr_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      data_q    <= '0;
      attr_q    <= '0;
      addr_lo_q <= '0;
    end else if (we) begin
      case (ofs)
        OFS_CTRL:    en_q      <= wdata[0];
        OFS_DATA:    data_q    <= wdata;
        OFS_ADDR_LO: addr_lo_q <= wdata[31:2];
        OFS_ATTR:    attr_q    <= wdata[ATTR_W-1:0];
        default:     ;
      endcase
    end
  end

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] addr_hi_q;
      always_ff @(posedge clk) begin
        if (!rst_n) addr_hi_q <= '0;
        else if (we && ofs == OFS_ADDR_HI) addr_hi_q <= wdata[HI_W-1:0];
      end
      if (HI_W < 32) begin : g_pad
        assign addr_full = {{(32-HI_W){1'b0}}, addr_hi_q, addr_lo_q, 2'b00};
      end else begin : g_nopad
        assign addr_full = {addr_hi_q, addr_lo_q, 2'b00};
      end
    end else begin : g_lo_only
      assign addr_full = {32'd0, addr_lo_q, 2'b00};
    end
  endgenerate

  always_comb begin
    case (ofs)
      OFS_CTRL:    rdata = {{(REG_W-1){1'b0}}, en_q};
      OFS_DATA:    rdata = data_q;
      OFS_ADDR_LO: rdata = addr_full[31:0];
      OFS_ADDR_HI: rdata = addr_full[63:32];
      OFS_ATTR:    rdata = {{(REG_W-ATTR_W){1'b0}}, attr_q};
      default:     rdata = '0;
    endcase
  end

  assign irq_en    = en_q;
  assign door_addr = addr_full;
  assign msg_word  = data_q;
  assign mem_attr  = attr_q;
endmodule

// File: rtl/msi_arm_detect.sv
module msi_arm_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic enable,
  input  logic addr_nz,
  output logic fire
);
  logic qual;
  logic qual_q;

  assign qual = ovf & enable & addr_nz;

  always_ff @(posedge clk) begin
    if (!rst_n) qual_q <= 1'b0;
    else        qual_q <= qual;
  end

  assign fire = qual & ~qual_q;
endmodule

// File: rtl/msi_req_hold.sv
module msi_req_hold #(
  parameter int PAY_W = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [PAY_W-1:0] pay_in,
  input  logic             ready,
  output logic             valid,
  output logic [PAY_W-1:0] pay_out
);
  logic             pending_q;
  logic [PAY_W-1:0] pay_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      pay_q     <= '0;
    end else if (!pending_q) begin
      if (fire) begin
        pending_q <= 1'b1;
        pay_q     <= pay_in;
      end
    end else if (ready) begin
      pending_q <= 1'b0;
    end
  end

  assign valid   = pending_q;
  assign pay_out = pay_q;
endmodule

// File: rtl/msi_doorbell_writer.sv
module msi_doorbell_writer
  import msi_pkg::*;
#(
  parameter int ADDR_BITS = 52,
  parameter int ATTR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_ofs,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              ovf_in,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data,
  output logic [ATTR_W-1:0] msg_attr
);
  localparam int PAY_W = 64 + REG_W + ATTR_W;

  logic              irq_en;
  logic [63:0]       door_addr;
  logic [REG_W-1:0]  msg_word;
  logic [ATTR_W-1:0] mem_attr;
  logic              fire;
  logic [PAY_W-1:0]  pay_out;

  msi_cfg_regs #(.ADDR_BITS(ADDR_BITS), .ATTR_W(ATTR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .ofs       (cfg_ofs),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .irq_en    (irq_en),
    .door_addr (door_addr),
    .msg_word  (msg_word),
    .mem_attr  (mem_attr)
  );

  msi_arm_detect u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovf     (ovf_in),
    .enable  (irq_en),
    .addr_nz (|door_addr),
    .fire    (fire)
  );

  msi_req_hold #(.PAY_W(PAY_W)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .pay_in  ({door_addr, msg_word, mem_attr}),
    .ready   (msg_ready),
    .valid   (msg_valid),
    .pay_out (pay_out)
  );

  assign msg_addr = pay_out[PAY_W-1 -: 64];
  assign msg_data = pay_out[ATTR_W +: REG_W];
  assign msg_attr = pay_out[ATTR_W-1:0];
endmodule

// File: rtl/msi_doorbell_writer_chk.sv
module msi_doorbell_writer_chk #(
  parameter int ADDR_BITS = 52,
  parameter int ATTR_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ovf_in,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [63:0]       msg_addr,
  input logic [31:0]       msg_data,
  input logic [ATTR_W-1:0] msg_attr
);
  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[1:0] == 2'b00) && ((msg_addr >> ADDR_BITS) == 64'd0));

  // R6
  addr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr != 64'd0));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) &&
                                   $stable(msg_data) && $stable(msg_attr)));

  // R8
  single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid);

  // R9
  launch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(ovf_in));
endmodule

bind msi_doorbell_writer msi_doorbell_writer_chk #(
  .ADDR_BITS(ADDR_BITS), .ATTR_W(ATTR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ovf_in    (ovf_in),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_addr  (msg_addr),
  .msg_data  (msg_data),
  .msg_attr  (msg_attr)
);

// File: tb/msi_doorbell_writer_test.sv
`timescale 1ns/1ps
module msi_doorbell_writer_test;
  typedef logic [99:0] item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_ofs;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        ovf_in;
  logic        msg_valid;
  logic        msg_ready;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic [3:0]  msg_attr;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R4";
  item_t expq[$];

  always #2 clk = ~clk;

  msi_doorbell_writer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ofs(cfg_ofs),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ovf_in(ovf_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .msg_attr(msg_attr)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: a handshake completes at the next rising edge
  always @(negedge clk) begin
    item_t e;
    if (rst_n && msg_valid && msg_ready) begin
      if (expq.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL %s R8 unexpected message actual=%h expected=none", cur_req, msg_addr);
      end else begin
        e = expq.pop_front();
        chk({cur_req, " message"}, {msg_addr, msg_data, msg_attr}, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input logic [4:0] o, input logic [31:0] v);
    cfg_we = 1'b1; cfg_ofs = o; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input logic [4:0] o, input logic [31:0] exp, input string req);
    cfg_ofs = o;
    #0.2;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic expect_quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, msg_valid, 1'b0);
    end
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 40 && expq.size() != 0; i++) tick();
    chk({cur_req, " drain"}, expq.size(), 0);
  endtask

  localparam logic [63:0] A = 64'h0000_0012_3456_7890;

  initial begin
    logic [99:0] held;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ofs = '0; cfg_wdata = '0;
    ovf_in = 1'b0; msg_ready = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    cfg_check(5'h00, 0, "R1 ctrl");
    cfg_check(5'h04, 0, "R1 data");
    cfg_check(5'h08, 0, "R1 addr lo");
    cfg_check(5'h0C, 0, "R1 addr hi");
    cfg_check(5'h10, 0, "R1 attr");
    chk("R1 valid", msg_valid, 1'b0);

    // R2 address masking
    cfg_write(5'h08, 32'hFFFF_FFFF);
    cfg_write(5'h0C, 32'hFFFF_FFFF);
    cfg_check(5'h08, 32'hFFFF_FFFC, "R2 addr lo");
    cfg_check(5'h0C, 32'h000F_FFFF, "R2 addr hi");
    cfg_write(5'h08, 32'h3456_7893);
    cfg_write(5'h0C, 32'h0000_0012);
    cfg_check(5'h08, 32'h3456_7890, "R2 addr lo value");

    // R3 register fields
    cfg_write(5'h04, 32'hCAFE_0001);
    cfg_write(5'h10, 32'hFFFF_FFFF);
    cfg_check(5'h10, 32'h0000_000F, "R3 attr width");
    cfg_write(5'h10, 32'h1);
    cfg_write(5'h00, 32'hFFFF_FFFF);
    cfg_check(5'h00, 32'h1, "R3 ctrl width");
    cfg_check(5'h04, 32'hCAFE_0001, "R3 data");
    cfg_check(5'h14, 32'h0, "R3 unmapped");

    // R5 enable clear
    cfg_write(5'h00, 32'h0);
    ovf_in = 1'b1;
    expect_quiet(6, "R5");
    ovf_in = 1'b0;
    tick();

    // R6 zero address
    cfg_write(5'h00, 32'h1);
    cfg_write(5'h08, 32'h0);
    cfg_write(5'h0C, 32'h0);
    ovf_in = 1'b1;
    expect_quiet(6, "R6");
    ovf_in = 1'b0;
    tick();
    cfg_write(5'h08, A[31:0]);
    cfg_write(5'h0C, A[63:32]);

    // R4 launch
    cur_req = "R4";
    expq.push_back({A, 32'hCAFE_0001, 4'h1});
    ovf_in = 1'b1;
    tick();
    chk("R4 valid after edge", msg_valid, 1'b1);
    tick();
    // R9 no repeat while overflow stays high
    expect_quiet(8, "R9 held high");
    ovf_in = 1'b0;
    tick(); tick();
    cur_req = "R9";
    expq.push_back({A, 32'hCAFE_0001, 4'h1});
    ovf_in = 1'b1;
    wait_drain();
    ovf_in = 1'b0;
    tick();

    // R7 stall, R8 merge, R10 payload latch
    msg_ready = 1'b0;
    cur_req = "R8";
    expq.push_back({A, 32'hCAFE_0001, 4'h1});
    ovf_in = 1'b1;
    tick();
    chk("R7 valid in stall", msg_valid, 1'b1);
    held = {msg_addr, msg_data, msg_attr};
    cfg_write(5'h04, 32'h1234_ABCD);
    cfg_write(5'h10, 32'h5);
    ovf_in = 1'b0;
    tick();
    ovf_in = 1'b1;
    tick();
    for (int i = 0; i < 3; i++) begin
      chk("R7 valid held", msg_valid, 1'b1);
      chk("R10 payload held", {msg_addr, msg_data, msg_attr}, held);
      tick();
    end
    msg_ready = 1'b1;
    wait_drain();
    tick();
    expect_quiet(4, "R8 single transfer");
    ovf_in = 1'b0;
    tick();
    cur_req = "R10";
    expq.push_back({A, 32'h1234_ABCD, 4'h5});
    ovf_in = 1'b1;
    wait_drain();
    ovf_in = 1'b0;
    tick(); tick();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule